// File: doc/BRIEF.md
# Stack Page Sequencer

This block owns the 8-bit stack pointer of a small processor core and runs every operation that moves data between the core and the stack. The stack is held in one fixed 256-byte page of memory. The pointer always names the next free byte in that page. The surrounding core issues one command at a time: push or pull of the accumulator or status byte, subroutine call and return, forced break, return from interrupt, and the two transfers between the X index and the pointer. With each command it supplies the current program counter, accumulator, status byte and X value.

The sequencer then generates the bus cycles for that command on a simple synchronous memory port. It has an address, write data, a write strobe and a read strobe, and read data returns one cycle after a read strobe. While the command runs, `busy` is high. In the cycle after the last step, `done` pulses, and the result outputs hold the new program counter, accumulator, status byte and X value. Each command takes a fixed number of cycles, counted from the accept cycle to the cycle in which the next command can be accepted.

Top module: `stk_seq`

## Requirements
- R1: A push writes at address {STACK_PAGE, S} and then decrements S. A pull reads at address {STACK_PAGE, S+1} and leaves S incremented. S wraps modulo 256 and never leaves the page: a push at S=0x00 writes 0x0100 and leaves 0xFF, and a pull at S=0xFF reads 0x0100 and leaves 0x00.
- R2: A command is accepted on an edge where cmd_valid is high and busy is low. busy then stays high for N-1 cycles, and done is high for one cycle, with busy low, in the cycle after that. N is 3 for a push, 4 for a pull, 6 for a call, return from subroutine or return from interrupt, 7 for a break, and 2 for a transfer. Read data is taken from mem_rdata in the cycle after the read strobe.
- R3: cmd_op 0 pushes the accumulator in cycle 1. cmd_op 1 pushes the status byte in cycle 1, with bit 5 forced to 1 and bit 4 forced to 0. Neither changes any result value.
- R4: cmd_op 2 pulls the accumulator in cycle 1. It sets status bit 7 (N) to bit 7 of the value and bit 1 (Z) to 1 when the value is zero, and keeps the other bits. cmd_op 3 pulls the status byte, with bit 5 forced to 1 and bit 4 forced to 0.
- R5: cmd_op 4 (call) reads PC+1 in cycle 1, pushes the high byte of PC+2 in cycle 2 and its low byte in cycle 3, and reads PC+2 in cycle 4. The new program counter has the first byte read as its low byte and the second as its high byte.
- R6: cmd_op 5 (return from subroutine) pulls the low byte in cycle 1 and the high byte in cycle 2. The new program counter is that address plus 1.
- R7: cmd_op 6 (break) pushes the high and low bytes of PC+2 in cycles 1 and 2. In cycle 3 it pushes the status byte with bits 5 and 4 set. It then sets status bit 2 (I), and reads the new program counter from BRK_VECTOR (low byte, cycle 4) and BRK_VECTOR+1 (high byte, cycle 5). An I bit that is already set does not block it.
- R8: cmd_op 7 (return from interrupt) pulls the status byte in cycle 1 (bit 5 forced to 1, bit 4 forced to 0), then the program counter low byte in cycle 2 and its high byte in cycle 3. The pulled address is used unchanged.
- R9: cmd_op 8 loads S from cmd_x and changes no flags. cmd_op 9 copies S to the X result and sets N and Z from S.
- R10: cmd_valid and the command inputs are ignored while busy is high. The bus cycles and results of the running command are unchanged.
- R11: After reset, S equals SP_INIT (default 0xFF), busy and done are low, and every result output is zero. No bus strobe is active while busy is low.
- R12: cmd_op codes 10 to 15 take 2 cycles, make no bus access and return the command values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_pc | input | 16 | Program counter of the command |
| cmd_a | input | 8 | Accumulator value |
| cmd_p | input | 8 | Status byte value |
| cmd_x | input | 8 | X index value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| res_pc | output | 16 | Resulting program counter |
| res_a | output | 8 | Resulting accumulator |
| res_p | output | 8 | Resulting status byte |
| res_x | output | 8 | Resulting X value |
| sp | output | 8 | Stack pointer |

## Verification
The bench goes after pointer wrap at both ends of the page. If the pointer carried into the high byte, a push would land outside page one, and a pull at 0xFF would read 0x0200. It checks the byte order of every multi-byte push and pull. Swapped bytes would return a mirrored program counter, and a missing +1 on return from subroutine would re-execute the last operand byte. It also checks that the break image carries bit 4 while a software status push does not, that break still proceeds with I already set, that the zero and negative flags come from a pulled value or from S, and that a command held on the inputs during a call neither restarts the call nor adds a stray push.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int DW     = 8;
    localparam int AW     = 16;
    localparam int STEP_W = 3;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_I = 2;
    localparam int FLG_D = 3;
    localparam int FLG_B = 4;
    localparam int FLG_U = 5;
    localparam int FLG_V = 6;
    localparam int FLG_N = 7;

    typedef enum logic [3:0] {
        OP_PUSH_A  = 4'd0,
        OP_PUSH_P  = 4'd1,
        OP_PULL_A  = 4'd2,
        OP_PULL_P  = 4'd3,
        OP_CALL    = 4'd4,
        OP_RET_SUB = 4'd5,
        OP_BREAK   = 4'd6,
        OP_RET_INT = 4'd7,
        OP_X_TO_S  = 4'd8,
        OP_S_TO_X  = 4'd9
    } stk_op_e;

    typedef enum logic [2:0] {
        W_A, W_P_SW, W_P_BRK, W_RET_HI, W_RET_LO
    } wsrc_e;

    typedef enum logic [2:0] {
        A_PUSH, A_PULL, A_OPND1, A_OPND2, A_VEC_LO, A_VEC_HI
    } asrc_e;

    typedef enum logic [1:0] {
        SP_HOLD, SP_INC, SP_DEC, SP_LOADX
    } sp_act_e;

    typedef enum logic [1:0] {
        CAP_NONE, CAP_LO, CAP_A, CAP_P
    } cap_e;

    typedef enum logic [1:0] {
        PC_KEEP, PC_RD_HI, PC_RD_HI_INC
    } pc_act_e;

    typedef struct packed {
        logic    mem_wr;
        wsrc_e   wsrc;
        logic    mem_rd;
        asrc_e   asrc;
        sp_act_e sp_act;
        cap_e    cap;
        pc_act_e pc_act;
        logic    set_i;
        logic    x_from_s;
        logic    last;
    } uop_t;

    function automatic uop_t u_push(wsrc_e w);
        uop_t u;
        u        = '0;
        u.mem_wr = 1'b1;
        u.wsrc   = w;
        u.asrc   = A_PUSH;
        u.sp_act = SP_DEC;
        return u;
    endfunction

    function automatic uop_t u_pull();
        uop_t u;
        u        = '0;
        u.mem_rd = 1'b1;
        u.asrc   = A_PULL;
        u.sp_act = SP_INC;
        return u;
    endfunction

    function automatic uop_t u_read(asrc_e a);
        uop_t u;
        u        = '0;
        u.mem_rd = 1'b1;
        u.asrc   = a;
        return u;
    endfunction

    function automatic logic [DW-1:0] nz_merge(logic [DW-1:0] p, logic [DW-1:0] v);
        logic [DW-1:0] r;
        r        = p;
        r[FLG_N] = v[DW-1];
        r[FLG_Z] = (v == '0);
        return r;
    endfunction

    function automatic logic [DW-1:0] push_image(logic [DW-1:0] p, logic brk);
        logic [DW-1:0] r;
        r        = p;
        r[FLG_U] = 1'b1;
        r[FLG_B] = brk;
        return r;
    endfunction

    function automatic logic [DW-1:0] pull_image(logic [DW-1:0] v);
        logic [DW-1:0] r;
        r        = v;
        r[FLG_U] = 1'b1;
        r[FLG_B] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/stk_ucode.sv
module stk_ucode
    import stk_pkg::*;
(
    input  stk_op_e             op,
    input  logic [STEP_W-1:0]   step,
    output uop_t                u
);

    always_comb begin
        u = '0;
        case (op)
            OP_PUSH_A: begin
                if (step == 3'd1) u = u_push(W_A);
                if (step == 3'd2) u.last = 1'b1;
            end
            OP_PUSH_P: begin
                if (step == 3'd1) u = u_push(W_P_SW);
                if (step == 3'd2) u.last = 1'b1;
            end
            OP_PULL_A: begin
                if (step == 3'd1) u = u_pull();
                if (step == 3'd2) u.cap = CAP_A;
                if (step == 3'd3) u.last = 1'b1;
            end
            OP_PULL_P: begin
                if (step == 3'd1) u = u_pull();
                if (step == 3'd2) u.cap = CAP_P;
                if (step == 3'd3) u.last = 1'b1;
            end
            OP_CALL: begin
                case (step)
                    3'd1: u = u_read(A_OPND1);
                    3'd2: begin u = u_push(W_RET_HI); u.cap = CAP_LO; end
                    3'd3: u = u_push(W_RET_LO);
                    3'd4: u = u_read(A_OPND2);
                    3'd5: begin u.pc_act = PC_RD_HI; u.last = 1'b1; end
                    default: ;
                endcase
            end
            OP_RET_SUB: begin
                case (step)
                    3'd1: u = u_pull();
                    3'd2: begin u = u_pull(); u.cap = CAP_LO; end
                    3'd3: u.pc_act = PC_RD_HI_INC;
                    3'd5: u.last = 1'b1;
                    default: ;
                endcase
            end
            OP_BREAK: begin
                case (step)
                    3'd1: u = u_push(W_RET_HI);
                    3'd2: u = u_push(W_RET_LO);
                    3'd3: begin u = u_push(W_P_BRK); u.set_i = 1'b1; end
                    3'd4: u = u_read(A_VEC_LO);
                    3'd5: begin u = u_read(A_VEC_HI); u.cap = CAP_LO; end
                    3'd6: begin u.pc_act = PC_RD_HI; u.last = 1'b1; end
                    default: ;
                endcase
            end
            OP_RET_INT: begin
                case (step)
                    3'd1: u = u_pull();
                    3'd2: begin u = u_pull(); u.cap = CAP_P; end
                    3'd3: begin u = u_pull(); u.cap = CAP_LO; end
                    3'd4: u.pc_act = PC_RD_HI;
                    3'd5: u.last = 1'b1;
                    default: ;
                endcase
            end
            OP_X_TO_S: begin
                if (step == 3'd1) begin u.sp_act = SP_LOADX; u.last = 1'b1; end
            end
            OP_S_TO_X: begin
                if (step == 3'd1) begin u.x_from_s = 1'b1; u.last = 1'b1; end
            end
            default: begin
                if (step == 3'd1) u.last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter logic [DW-1:0] SP_INIT = 8'hFF
) (
    input  logic          clk,
    input  logic          rst,
    input  sp_act_e       act,
    input  logic [DW-1:0] x_in,
    output logic [DW-1:0] sp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_INIT;
        end else begin
            case (act)
                SP_INC:   sp <= sp + 1'b1;
                SP_DEC:   sp <= sp - 1'b1;
                SP_LOADX: sp <= x_in;
                default:  sp <= sp;
            endcase
        end
    end

endmodule

// File: rtl/stk_addr.sv
module stk_addr
    import stk_pkg::*;
#(
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [AW-1:0] BRK_VECTOR = 16'hFFFE
) (
    input  asrc_e         sel,
    input  logic [DW-1:0] sp,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr
);

    logic [DW-1:0] sp_next;
    assign sp_next = sp + 1'b1;

    always_comb begin
        case (sel)
            A_PUSH:   addr = {STACK_PAGE, sp};
            A_PULL:   addr = {STACK_PAGE, sp_next};
            A_OPND1:  addr = base + 16'd1;
            A_OPND2:  addr = base + 16'd2;
            A_VEC_LO: addr = BRK_VECTOR;
            A_VEC_HI: addr = BRK_VECTOR + 16'd1;
            default:  addr = {STACK_PAGE, sp};
        endcase
    end

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
#(
    parameter logic [7:0]  SP_INIT    = 8'hFF,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] BRK_VECTOR = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_op,
    input  logic [15:0] cmd_pc,
    input  logic [7:0]  cmd_a,
    input  logic [7:0]  cmd_p,
    input  logic [7:0]  cmd_x,
    output logic        busy,
    output logic        done,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] res_pc,
    output logic [7:0]  res_a,
    output logic [7:0]  res_p,
    output logic [7:0]  res_x,
    output logic [7:0]  sp
);

    stk_op_e           op_q;
    logic [STEP_W-1:0] step_q;
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     pc_q;
    logic [AW-1:0]     ret_addr;
    logic [DW-1:0]     a_q, p_q, x_q, lo_q;
    logic              done_q;
    logic              accept;
    uop_t              uop;
    sp_act_e           sp_act;

    assign busy     = (step_q != '0);
    assign accept   = cmd_valid && !busy;
    assign ret_addr = base_q + 16'd2;
    assign sp_act   = busy ? uop.sp_act : SP_HOLD;

    stk_ucode u_ucode (
        .op   (op_q),
        .step (step_q),
        .u    (uop)
    );

    stk_ptr #(.SP_INIT(SP_INIT)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .act  (sp_act),
        .x_in (x_q),
        .sp   (sp)
    );

    stk_addr #(.STACK_PAGE(STACK_PAGE), .BRK_VECTOR(BRK_VECTOR)) u_addr (
        .sel  (uop.asrc),
        .sp   (sp),
        .base (base_q),
        .addr (mem_addr)
    );

    assign mem_we = busy && uop.mem_wr;
    assign mem_re = busy && uop.mem_rd;

    always_comb begin
        case (uop.wsrc)
            W_A:      mem_wdata = a_q;
            W_P_SW:   mem_wdata = push_image(p_q, 1'b0);
            W_P_BRK:  mem_wdata = push_image(p_q, 1'b1);
            W_RET_HI: mem_wdata = ret_addr[15:8];
            W_RET_LO: mem_wdata = ret_addr[7:0];
            default:  mem_wdata = a_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_PUSH_A;
            step_q <= '0;
            base_q <= '0;
            pc_q   <= '0;
            a_q    <= '0;
            p_q    <= '0;
            x_q    <= '0;
            lo_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                op_q   <= stk_op_e'(cmd_op);
                step_q <= 3'd1;
                base_q <= cmd_pc;
                pc_q   <= cmd_pc;
                a_q    <= cmd_a;
                p_q    <= cmd_p;
                x_q    <= cmd_x;
            end else if (busy) begin
                step_q <= uop.last ? '0 : step_q + 1'b1;
                done_q <= uop.last;
                case (uop.cap)
                    CAP_LO: lo_q <= mem_rdata;
                    CAP_A: begin
                        a_q <= mem_rdata;
                        p_q <= nz_merge(p_q, mem_rdata);
                    end
                    CAP_P:  p_q <= pull_image(mem_rdata);
                    default: ;
                endcase
                if (uop.set_i) p_q[FLG_I] <= 1'b1;
                if (uop.x_from_s) begin
                    x_q <= sp;
                    p_q <= nz_merge(p_q, sp);
                end
                case (uop.pc_act)
                    PC_RD_HI:     pc_q <= {mem_rdata, lo_q};
                    PC_RD_HI_INC: pc_q <= {mem_rdata, lo_q} + 16'd1;
                    default: ;
                endcase
            end
        end
    end

    assign done   = done_q;
    assign res_pc = pc_q;
    assign res_a  = a_q;
    assign res_p  = p_q;
    assign res_x  = x_q;

    // R1
    push_page_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == {STACK_PAGE, sp}));

    // R1
    push_dec_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp == $past(sp) - 8'd1));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !uop.last) |=> (busy && $stable(op_q) && $stable(base_q)));

    // R7
    brk_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (done && op_q == OP_BREAK) |-> res_p[FLG_I]);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re));

endmodule

// File: tb/stk_seq_bench.sv
`timescale 1ns/1ps
module stk_seq_bench;

    localparam bit [3:0] C_PUSH_A = 4'd0, C_PUSH_P = 4'd1, C_PULL_A = 4'd2, C_PULL_P = 4'd3;
    localparam bit [3:0] C_CALL = 4'd4, C_RTS = 4'd5, C_BRK = 4'd6, C_RTI = 4'd7;
    localparam bit [3:0] C_XS = 4'd8, C_SX = 4'd9, C_BAD = 4'd15;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [15:0] cmd_pc = '0;
    logic [7:0]  cmd_a = '0, cmd_p = '0, cmd_x = '0;
    logic        busy, done, mem_we, mem_re;
    logic [15:0] mem_addr, res_pc;
    logic [7:0]  mem_wdata, res_a, res_p, res_x, sp;
    logic [7:0]  mem_rdata = '0;

    stk_seq u_stk_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pc(cmd_pc), .cmd_a(cmd_a), .cmd_p(cmd_p), .cmd_x(cmd_x),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .res_pc(res_pc), .res_a(res_a), .res_p(res_p), .res_x(res_x), .sp(sp)
    );

    bit [7:0] ram [bit [15:0]];
    bit [7:0] mdl [bit [15:0]];

    function automatic bit [7:0] ram_rd(bit [15:0] a);
        return ram.exists(a) ? ram[a] : 8'h00;
    endfunction

    function automatic bit [7:0] mdl_rd(bit [15:0] a);
        return mdl.exists(a) ? mdl[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= ram_rd(mem_addr);
        if (mem_we) ram[mem_addr] = mem_wdata;
    end

    int vecs = 0;
    int errs = 0;

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    bit [7:0]  m_s = 8'hFF, m_p, m_a, m_x;
    bit [15:0] m_pc;
    bit        e_we [8];
    bit        e_re [8];
    bit [15:0] e_ad [8];
    bit [7:0]  e_wd [8];

    task automatic xpush(int k, bit [7:0] v);
        e_we[k] = 1'b1; e_ad[k] = {8'h01, m_s}; e_wd[k] = v;
        mdl[{8'h01, m_s}] = v;
        m_s = m_s - 8'd1;
    endtask

    task automatic xpull(int k, output bit [7:0] v);
        m_s = m_s + 8'd1;
        e_re[k] = 1'b1; e_ad[k] = {8'h01, m_s};
        v = mdl_rd({8'h01, m_s});
    endtask

    task automatic xread(int k, bit [15:0] ad, output bit [7:0] v);
        e_re[k] = 1'b1; e_ad[k] = ad;
        v = mdl_rd(ad);
    endtask

    function automatic bit [7:0] nz(bit [7:0] p, bit [7:0] v);
        bit [7:0] r;
        r = p; r[7] = v[7]; r[1] = (v == 8'h00);
        return r;
    endfunction

    function automatic bit [7:0] fix_p(bit [7:0] v);
        return (v | 8'h20) & 8'hEF;
    endfunction

    task automatic run(string req, bit [3:0] op, bit [15:0] pc, bit [7:0] a, bit [7:0] p,
                       bit [7:0] x, bit junk);
        int n;
        bit [7:0] lo, hi, v;
        bit [15:0] ret;
        for (int i = 0; i < 8; i++) begin
            e_we[i] = 0; e_re[i] = 0; e_ad[i] = '0; e_wd[i] = '0;
        end
        m_pc = pc; m_a = a; m_p = p; m_x = x; ret = pc + 16'd2;
        case (op)
            C_PUSH_A: begin n = 3; xpush(1, a); end
            C_PUSH_P: begin n = 3; xpush(1, fix_p(p)); end
            C_PULL_A: begin n = 4; xpull(1, v); m_a = v; m_p = nz(p, v); end
            C_PULL_P: begin n = 4; xpull(1, v); m_p = fix_p(v); end
            C_CALL: begin
                n = 6; xread(1, pc + 16'd1, lo); xpush(2, ret[15:8]); xpush(3, ret[7:0]);
                xread(4, pc + 16'd2, hi); m_pc = {hi, lo};
            end
            C_RTS: begin n = 6; xpull(1, lo); xpull(2, hi); m_pc = {hi, lo} + 16'd1; end
            C_BRK: begin
                n = 7; xpush(1, ret[15:8]); xpush(2, ret[7:0]); xpush(3, p | 8'h30);
                m_p = p | 8'h04; xread(4, 16'hFFFE, lo); xread(5, 16'hFFFF, hi); m_pc = {hi, lo};
            end
            C_RTI: begin
                n = 6; xpull(1, v); m_p = fix_p(v); xpull(2, lo); xpull(3, hi); m_pc = {hi, lo};
            end
            C_XS: begin n = 2; m_s = x; end
            C_SX: begin n = 2; m_x = m_s; m_p = nz(p, m_s); end
            default: n = 2;
        endcase
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_a = a; cmd_p = p; cmd_x = x;
        @(negedge clk);
        if (junk) begin
            cmd_op = C_PUSH_A; cmd_a = 8'hEE; cmd_pc = 16'h0BAD;
        end else begin
            cmd_valid = 1'b0;
        end
        for (int k = 1; k < n; k++) begin
            chk(req, "busy", {15'd0, busy}, 16'd1);
            chk(req, "done", {15'd0, done}, 16'd0);
            chk(req, "we", {15'd0, mem_we}, {15'd0, e_we[k]});
            chk(req, "re", {15'd0, mem_re}, {15'd0, e_re[k]});
            if (e_we[k] || e_re[k]) chk(req, "addr", mem_addr, e_ad[k]);
            if (e_we[k]) chk(req, "wdata", {8'd0, mem_wdata}, {8'd0, e_wd[k]});
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(req, "busy end", {15'd0, busy}, 16'd0);
        chk(req, "done end", {15'd0, done}, 16'd1);
        chk(req, "res_pc", res_pc, m_pc);
        chk(req, "res_a", {8'd0, res_a}, {8'd0, m_a});
        chk(req, "res_p", {8'd0, res_p}, {8'd0, m_p});
        chk(req, "res_x", {8'd0, res_x}, {8'd0, m_x});
        chk(req, "sp", {8'd0, sp}, {8'd0, m_s});
    endtask

    initial begin
        #(5.0 * 100000);
        errs++;
        $display("FAIL R2 watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        ram[16'h1235] = 8'h78; ram[16'h1236] = 8'h56;
        ram[16'h40FF] = 8'h34; ram[16'h4100] = 8'h12;
        ram[16'hFFFE] = 8'h00; ram[16'hFFFF] = 8'hC0;
        mdl[16'h1235] = 8'h78; mdl[16'h1236] = 8'h56;
        mdl[16'h40FF] = 8'h34; mdl[16'h4100] = 8'h12;
        mdl[16'hFFFE] = 8'h00; mdl[16'hFFFF] = 8'hC0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "sp", {8'd0, sp}, 16'h00FF);
        chk("R11", "busy", {15'd0, busy}, 16'd0);
        chk("R11", "done", {15'd0, done}, 16'd0);
        chk("R11", "strobes", {14'd0, mem_we, mem_re}, 16'd0);
        chk("R11", "res_pc", res_pc, 16'h0000);
        chk("R11", "res_p", {8'd0, res_p}, 16'h0000);

        run("R3", C_PUSH_A, 16'h0300, 8'h5A, 8'h00, 8'h00, 0);
        run("R3", C_PUSH_P, 16'h0300, 8'h11, 8'hD3, 8'h00, 0);
        run("R4", C_PULL_P, 16'h0300, 8'h11, 8'h00, 8'h00, 0);
        run("R4", C_PULL_A, 16'h0300, 8'h00, 8'h00, 8'h00, 0);
        run("R3", C_PUSH_A, 16'h0300, 8'h00, 8'h00, 8'h00, 0);
        run("R4", C_PULL_A, 16'h0300, 8'h77, 8'hFF, 8'h00, 0);
        run("R3", C_PUSH_A, 16'h0300, 8'h80, 8'h00, 8'h00, 0);
        run("R4", C_PULL_A, 16'h0300, 8'h01, 8'h02, 8'h00, 0);

        run("R5", C_CALL, 16'h1234, 8'h00, 8'h00, 8'h00, 0);
        run("R6", C_RTS, 16'h5678, 8'h00, 8'h00, 8'h00, 0);

        run("R7", C_BRK, 16'h2000, 8'h00, 8'h04, 8'h00, 0);
        run("R8", C_RTI, 16'hC000, 8'h00, 8'h04, 8'h00, 0);
        run("R7", C_BRK, 16'h20FF, 8'h00, 8'hC1, 8'h00, 0);
        run("R8", C_RTI, 16'hC000, 8'h00, 8'h00, 8'h00, 0);

        run("R9", C_XS, 16'h0000, 8'h00, 8'h00, 8'h00, 0);
        run("R1", C_PUSH_A, 16'h0000, 8'h3C, 8'h00, 8'h00, 0);
        run("R9", C_XS, 16'h0000, 8'h00, 8'hAA, 8'hFF, 0);
        run("R1", C_PULL_A, 16'h0000, 8'h00, 8'h00, 8'h00, 0);
        run("R9", C_SX, 16'h0000, 8'h00, 8'h80, 8'h55, 0);
        run("R9", C_XS, 16'h0000, 8'h00, 8'h00, 8'h80, 0);
        run("R9", C_SX, 16'h0000, 8'h00, 8'h02, 8'h00, 0);

        run("R10", C_CALL, 16'h40FE, 8'h00, 8'h00, 8'h00, 1);
        run("R6", C_RTS, 16'h1234, 8'h00, 8'h00, 8'h00, 0);
        run("R12", C_BAD, 16'h7777, 8'h12, 8'h34, 8'h56, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule